// File: doc/BRIEF.md
# Response Frame Serializer with Length Adaptation

This block turns one response word into a serial reply frame: the data bits go out most significant first, then a 4-bit CRC computed over exactly the data bits that went out. A load carries the response value, its natural width (8, 10 or 16 bits), the reply format, and a programmable CRC polynomial and seed. The block fits the data to the reply format before sending it. It left-aligns the natural-width value, keeps as many top bits as the format needs, and fills any missing low bits with zeros.

The load interface is valid/ready. `in_ready` is always high, so a load is taken on any cycle. A load that arrives while a frame is still going out abandons that frame, starts the new one, and raises `truncated` for one cycle. The bit stream is also valid/ready. A bit moves on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_bit` and `out_valid` hold their values, so the consumer's shift strobe can set the pace freely.

The standard reply formats always use the fixed CRC settings. The enhanced formats use the polynomial and seed that were captured at load.

Top module: `rsp_serializer`

## Requirements
- R1: `in_ready` is always 1. The cycle after `in_valid` is sampled high, `out_valid` is 1 and `out_bit` shows the first data bit of the new frame.
- R2: Formats 0 (standard long), 4 (enhanced long) and the unused codes 5 to 7 send 16 data bits and then 4 CRC bits, 20 transfers in total. The CRC goes out from its top bit down to bit 0.
- R3: Formats 1 (standard short) and 2 (enhanced short, 8 bits) send 8 data bits and then 4 CRC bits.
- R4: Format 3 (enhanced short, 10 bits) sends 10 data bits and then 4 CRC bits.
- R5: Width codes are 0 = 8 bits, 1 = 10 bits, 2 or 3 = 16 bits, with the value right-justified in `in_word`. The value is left-aligned and the top bits are sent. When the format needs more bits than the natural width, zeros are appended on the right. When it needs fewer, the low bits are dropped. For example, an 8-bit value sent as a 10-bit reply ends in two zeros, and a 10-bit value sent as an 8-bit reply loses its two least significant bits.
- R6: Formats 0 and 1 use polynomial x^4+1 (coefficient vector 0001) and seed 1010, whatever `crc_poly` and `crc_seed` hold.
- R7: Formats 2, 3 and 4 use `crc_poly` (bits 3..0 are the coefficients of x^3..x^0, with x^4 implied) and `crc_seed`, both captured at load. Each data bit d updates the register c as follows: c becomes (c shifted left by one) XOR (poly if c[3] XOR d is 1).
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_bit` stays the same and `out_valid` stays 1.
- R9: `done` is 1 for exactly one cycle, in the cycle after the final CRC bit is transferred. `out_valid` is 0 in that cycle unless a new load was taken.
- R10: A load taken while a frame is unfinished raises `truncated` for one cycle and starts the new frame. `done` is not raised for the abandoned frame.
- R11: After reset, `out_valid`, `done` and `truncated` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Load request for a new response |
| in_ready | output | 1 | Always 1 |
| in_word | input | 16 | Response value, right-justified |
| in_width | input | 2 | Natural width code |
| in_fmt | input | 3 | Reply format code |
| crc_poly | input | 4 | Polynomial for enhanced formats |
| crc_seed | input | 4 | Seed for enhanced formats |
| out_valid | output | 1 | A frame bit is available |
| out_ready | input | 1 | Shift strobe from the consumer |
| out_bit | output | 1 | Current frame bit |
| done | output | 1 | One-cycle pulse after the last CRC bit |
| truncated | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The same 16-bit value is sent in a standard format with two different `crc_poly`/`crc_seed` settings. This separates a CRC that ignores those inputs from one that leaks them in. Enhanced short replies are sent from 10-bit values into the 8-bit format and from 8-bit values into the 10-bit format, as well as natively. These cases separate correct padding from correct truncation and from an off-by-two shift. An enhanced long reply with a non-default polynomial checks the programmable path. Further tests stall the consumer on an irregular pattern, hold it off for several cycles, and load again mid-frame, which exercises hold behaviour and the abort path.

// File: rtl/rsp_ser_pkg.sv
package rsp_ser_pkg;

  typedef enum logic [2:0] {
    FMT_STD_LONG    = 3'd0,
    FMT_STD_SHORT   = 3'd1,
    FMT_ENH_SHORT8  = 3'd2,
    FMT_ENH_SHORT10 = 3'd3,
    FMT_ENH_LONG    = 3'd4
  } rsp_fmt_e;

  typedef enum logic [1:0] {
    NAT_W8  = 2'd0,
    NAT_W10 = 2'd1,
    NAT_W16 = 2'd2
  } nat_width_e;

  localparam int unsigned CRC_W = 4;

  // One serial CRC step: shift left, fold in the polynomial when the
  // outgoing top bit differs from the incoming data bit.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [CRC_W-1:0] poly,
                                                input logic d);
    return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{c[CRC_W-1] ^ d}} & poly);
  endfunction

endpackage

// File: rtl/rsp_fmt_adapt.sv
module rsp_fmt_adapt
  import rsp_ser_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SHORT_W  = 8,
  parameter int unsigned EXT_W    = 10,
  parameter int unsigned CW       = 4,
  parameter logic [CW-1:0] STD_POLY = 4'b0001,
  parameter logic [CW-1:0] STD_SEED = 4'b1010,
  localparam int unsigned CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        width,
  input  logic [2:0]        fmt,
  input  logic [CW-1:0]     poly,
  input  logic [CW-1:0]     seed,
  output logic [DATA_W-1:0] frame,
  output logic [CNT_W-1:0]  nbits,
  output logic [CW-1:0]     poly_sel,
  output logic [CW-1:0]     seed_sel
);

  logic [CNT_W-1:0]  nat;
  logic [CNT_W-1:0]  keep;
  logic [CNT_W-1:0]  thresh;
  logic [CNT_W-1:0]  sh;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] keep_mask;
  logic              enh;

  always_comb begin
    case (width)
      NAT_W8:  nat = CNT_W'(SHORT_W);
      NAT_W10: nat = CNT_W'(EXT_W);
      default: nat = CNT_W'(DATA_W);
    endcase
    case (fmt)
      FMT_STD_SHORT,
      FMT_ENH_SHORT8:  keep = CNT_W'(SHORT_W);
      FMT_ENH_SHORT10: keep = CNT_W'(EXT_W);
      default:         keep = CNT_W'(DATA_W);
    endcase
    enh     = (fmt == FMT_ENH_SHORT8) || (fmt == FMT_ENH_SHORT10) ||
              (fmt == FMT_ENH_LONG);
    sh      = CNT_W'(DATA_W) - nat;
    thresh  = CNT_W'(DATA_W) - keep;
    aligned = word << sh;
  end

  // Keep only the top 'keep' bits of the left-aligned value.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep_mask[i] = (CNT_W'(i) >= thresh);
  end

  assign frame    = aligned & keep_mask;
  assign nbits    = keep;
  assign poly_sel = enh ? poly : STD_POLY;
  assign seed_sel = enh ? seed : STD_SEED;

endmodule

// File: rtl/rsp_crc_unit.sv
module rsp_crc_unit
  import rsp_ser_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] seed_in,
  input  logic [CW-1:0] poly_in,
  input  logic          step_data,
  input  logic          data_bit,
  input  logic          step_out,
  output logic          crc_msb
);

  logic [CW-1:0] crc_q;
  logic [CW-1:0] poly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      poly_q <= '0;
    end else if (load) begin
      crc_q  <= seed_in;
      poly_q <= poly_in;
    end else if (step_data) begin
      crc_q  <= crc_step(crc_q, poly_q, data_bit);
    end else if (step_out) begin
      crc_q  <= {crc_q[CW-2:0], 1'b0};
    end
  end

  assign crc_msb = crc_q[CW-1];

  // R2
  crc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_out && !load) |=> (crc_q[CW-1] == $past(crc_q[CW-2])));

endmodule

// File: rtl/rsp_bit_seq.sv
module rsp_bit_seq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CW     = 4,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] frame,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              data_msb,
  output logic              crc_phase,
  output logic              step_data,
  output logic              step_out,
  output logic              done,
  output logic              truncated
);

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              busy;
  logic              crc_ph;
  logic              done_q;
  logic              trunc_q;
  logic              xfer;
  logic              last;

  assign xfer      = busy && out_ready;
  assign last      = xfer && crc_ph && (cnt == CNT_W'(1));
  assign step_data = xfer && !crc_ph && !load;
  assign step_out  = xfer && crc_ph && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      crc_ph  <= 1'b0;
      done_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      done_q  <= last;
      trunc_q <= load && busy && !last;
      if (load) begin
        sreg   <= frame;
        cnt    <= nbits;
        busy   <= 1'b1;
        crc_ph <= 1'b0;
      end else if (xfer) begin
        if (!crc_ph) begin
          sreg <= sreg << 1;
          if (cnt == CNT_W'(1)) begin
            crc_ph <= 1'b1;
            cnt    <= CNT_W'(CW);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end else if (cnt == CNT_W'(1)) begin
          busy   <= 1'b0;
          crc_ph <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  assign out_valid = busy;
  assign data_msb  = sreg[DATA_W-1];
  assign crc_phase = crc_ph;
  assign done      = done_q;
  assign truncated = trunc_q;

  // R1
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(data_msb) && $stable(crc_phase)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(load)) |-> !out_valid);
  // R10
  trunc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    truncated |-> ($past(load) && !done));

endmodule

// File: rtl/rsp_serializer.sv
module rsp_serializer
  import rsp_ser_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned EXT_W   = 10,
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  input  logic [1:0]        in_width,
  input  logic [2:0]        in_fmt,
  input  logic [CRC_W-1:0]  crc_poly,
  input  logic [CRC_W-1:0]  crc_seed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              done,
  output logic              truncated
);

  logic [DATA_W-1:0] frame;
  logic [CNT_W-1:0]  nbits;
  logic [CRC_W-1:0]  poly_sel;
  logic [CRC_W-1:0]  seed_sel;
  logic              data_msb;
  logic              crc_msb;
  logic              crc_phase;
  logic              step_data;
  logic              step_out;

  assign in_ready = 1'b1;

  rsp_fmt_adapt #(
    .DATA_W(DATA_W), .SHORT_W(SHORT_W), .EXT_W(EXT_W), .CW(CRC_W),
    .STD_POLY(4'b0001), .STD_SEED(4'b1010)
  ) u_adapt (
    .word(in_word), .width(in_width), .fmt(in_fmt),
    .poly(crc_poly), .seed(crc_seed),
    .frame(frame), .nbits(nbits), .poly_sel(poly_sel), .seed_sel(seed_sel)
  );

  rsp_bit_seq #(.DATA_W(DATA_W), .CW(CRC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .frame(frame), .nbits(nbits),
    .out_ready(out_ready), .out_valid(out_valid), .data_msb(data_msb),
    .crc_phase(crc_phase), .step_data(step_data), .step_out(step_out),
    .done(done), .truncated(truncated)
  );

  rsp_crc_unit #(.CW(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .seed_in(seed_sel),
    .poly_in(poly_sel), .step_data(step_data), .data_bit(data_msb),
    .step_out(step_out), .crc_msb(crc_msb)
  );

  assign out_bit = crc_phase ? crc_msb : data_msb;

endmodule

// File: tb/rsp_serializer_tb_top.sv
`timescale 1ns/1ps
module rsp_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [1:0]  in_width = '0;
  logic [2:0]  in_fmt = '0;
  logic [3:0]  crc_poly = '0;
  logic [3:0]  crc_seed = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_bit;
  logic        done;
  logic        truncated;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rsp_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_width(in_width), .in_fmt(in_fmt),
    .crc_poly(crc_poly), .crc_seed(crc_seed), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .done(done), .truncated(truncated)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model of the frame, built from the requirements.
  task automatic model(input logic [15:0] w, input logic [1:0] wc, input logic [2:0] fc,
                       input logic [3:0] p, input logic [3:0] s,
                       output logic [19:0] bits, output int len);
    int n, k;
    logic [3:0] c, pp;
    logic b, fb, enh;
    n   = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 10 : 16;
    k   = (fc == 3'd1 || fc == 3'd2) ? 8 : (fc == 3'd3) ? 10 : 16;
    enh = (fc == 3'd2 || fc == 3'd3 || fc == 3'd4);
    pp  = enh ? p : 4'b0001;
    c   = enh ? s : 4'b1010;
    bits = '0;
    for (int i = 0; i < k; i++) begin
      b  = (n - 1 - i >= 0) ? w[n-1-i] : 1'b0;
      bits[19-i] = b;
      fb = c[3] ^ b;
      c  = {c[2:0], 1'b0};
      if (fb) c = c ^ pp;
    end
    for (int j = 0; j < 4; j++) bits[19-k-j] = c[3-j];
    len = k + 4;
  endtask

  task automatic load(input logic [15:0] w, input logic [1:0] wc, input logic [2:0] fc,
                      input logic [3:0] p, input logic [3:0] s);
    @(negedge clk);
    out_ready = 1'b0;
    in_word = w; in_width = wc; in_fmt = fc; crc_poly = p; crc_seed = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    crc_poly = ~p; crc_seed = ~s;
  endtask

  // Receives len bits starting at the current negedge; then checks done.
  task automatic recv(input int len, input bit stall, input string req, output logic [19:0] got);
    int k = 0;
    int cyc = 0;
    got = '0;
    while (k < len && cyc < 400) begin
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      if (out_valid && out_ready) begin
        got[19-k] = out_bit;
        k++;
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(k == len, req, k, len);
    // R9: done one cycle after the last CRC bit, stream idle
    chk(done == 1'b1 && out_valid == 1'b0, "R9", {done, out_valid}, 2'b10);
    chk(truncated == 1'b0, "R10", truncated, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", done, 0);
  endtask

  task automatic run_frame(input string req, input logic [15:0] w, input logic [1:0] wc,
                           input logic [2:0] fc, input logic [3:0] p, input logic [3:0] s,
                           input bit stall);
    logic [19:0] exp, got;
    int len;
    model(w, wc, fc, p, s, exp, len);
    load(w, wc, fc, p, s);
    // R1: first data bit presented the cycle after load
    chk(out_valid && in_ready && out_bit == exp[19], "R1", {out_valid, out_bit}, {1'b1, exp[19]});
    recv(len, stall, req, got);
    chk(got == exp, req, got, exp);
  endtask

  task automatic test_reset();
    // R11
    chk(out_valid == 1'b0 && done == 1'b0 && truncated == 1'b0, "R11",
        {out_valid, done, truncated}, 0);
  endtask

  task automatic test_hold();
    logic [19:0] exp, got;
    int len;
    logic first;
    model(16'h3C96, 2'd2, 3'd4, 4'h9, 4'h5, exp, len);
    load(16'h3C96, 2'd2, 3'd4, 4'h9, 4'h5);
    first = out_bit;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R8: held while the consumer stalls
      chk(out_valid && out_bit == first, "R8", {out_valid, out_bit}, {1'b1, first});
    end
    recv(len, 1'b0, "R8", got);
    chk(got == exp, "R8", got, exp);
  endtask

  task automatic test_abort();
    logic [19:0] exp, got;
    int len;
    load(16'hF00F, 2'd2, 3'd0, 4'h0, 4'h0);
    for (int i = 0; i < 5; i++) begin
      out_ready = 1'b1;
      @(negedge clk);
    end
    model(16'h00B4, 2'd0, 3'd1, 4'h0, 4'h0, exp, len);
    load(16'h00B4, 2'd0, 3'd1, 4'h0, 4'h0);
    // R10: abandoned frame flagged, new frame starts
    chk(truncated == 1'b1 && done == 1'b0, "R10", {truncated, done}, 2'b10);
    chk(out_valid && out_bit == exp[19], "R10", {out_valid, out_bit}, {1'b1, exp[19]});
    recv(len, 1'b0, "R10", got);
    chk(got == exp, "R10", got, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    // R2 / R6: standard long, two different programmable settings, same frame
    run_frame("R2", 16'hA5C3, 2'd2, 3'd0, 4'hF, 4'h0, 1'b0);
    run_frame("R6", 16'hA5C3, 2'd2, 3'd0, 4'h3, 4'h7, 1'b0);
    // R3: standard short and enhanced 8-bit short
    run_frame("R3", 16'h005A, 2'd0, 3'd1, 4'h6, 4'h1, 1'b0);
    run_frame("R3", 16'h00E1, 2'd0, 3'd2, 4'hB, 4'h4, 1'b0);
    // R5: 10-bit value into 8-bit reply drops low bits
    run_frame("R5", 16'h02B7, 2'd1, 3'd2, 4'h3, 4'hF, 1'b0);
    // R5: 8-bit value into 10-bit reply pads zeros
    run_frame("R5", 16'h00C6, 2'd0, 3'd3, 4'h3, 4'h2, 1'b0);
    // R4: native 10-bit reply
    run_frame("R4", 16'h0379, 2'd1, 3'd3, 4'h5, 4'hA, 1'b0);
    // R7: enhanced long with programmed polynomial and seed
    run_frame("R7", 16'h1234, 2'd2, 3'd4, 4'h3, 4'hF, 1'b0);
    run_frame("R7", 16'h00FF, 2'd0, 3'd4, 4'hD, 4'h6, 1'b0);
    // R8: irregular consumer stalls
    run_frame("R8", 16'h0155, 2'd1, 3'd3, 4'h7, 4'h9, 1'b1);
    test_hold();
    test_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule